// File: doc/BRIEF.md
# Cascaded Input Expander Scanner

This block polls a chain of 8-bit parallel-in, serial-out shift registers over a serial link that works like SPI, and presents every captured byte on its own parallel output port. A scan starts with a low pulse on the active-low load line, which makes every device in the chain latch its parallel inputs. The load line then returns high, and after a quiet half period the block issues eight serial clocks per device while it samples the incoming serial data.

Scans start in two ways. A free-running interval timer launches one every `INTERVAL` system cycles, and a `start` pulse requests one at once. Every launch restarts the timer. All output ports update together at the end of a scan, in the same cycle as a one-cycle `done` pulse. The outgoing data line only carries filler zeros.

Top module: `din_chain_scanner`

## Requirements
- R1: After reset `load_n` is 1, `sclk` is 0, `done` is 0 and `dout` is all zeros.
- R2: Each scan drives `load_n` low for exactly `DIV` system cycles, and only once per scan. `sclk` stays low while `load_n` is low. Parallel inputs that change after the load are not captured.
- R3: The first rising edge of `sclk` comes exactly `DIV/2` cycles after `load_n` returns high.
- R4: `sclk` is high for `DIV/2` cycles in every period, and consecutive rising edges are `DIV` cycles apart. A scan has exactly `8*N_DEV` rising edges. `miso` is sampled at each rising edge.
- R5: The first bit received becomes bit 7 of port 0, so port 0 is `dout[7:0]` and each byte arrives most significant bit first. The k-th received byte (k counted from 0) lands in `dout[8k+7:8k]`.
- R6: `mosi` is 0 at all times.
- R7: `dout` changes only in the cycle where `done` is high. `done` is high for exactly one cycle per scan.
- R8: `done` goes high `DIV*(8*N_DEV+1)+1` cycles after the clock edge that accepts `start`.
- R9: Without `start`, scans launch every `INTERVAL` cycles, so consecutive `done` pulses are `INTERVAL` cycles apart. A `start` restarts this interval.
- R10: A `start` that arrives during a scan is ignored. It neither adds a scan nor moves the next timed launch.
- R11: A `start` in the same cycle as a timer expiry produces a single scan, and the timer restarts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a scan now (ignored while a scan runs) |
| miso | input | 1 | Serial data from the nearest device of the chain |
| load_n | output | 1 | Active-low parallel-load line to all devices |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Outgoing serial data, always zero |
| dout | output | 8*N_DEV | Captured bytes; byte k is the k-th byte received |
| done | output | 1 | One-cycle pulse when `dout` takes a new scan |

## Verification
The two triggers can collide: a manual `start` can land in the exact cycle where the interval timer expires. The bench measures when an earlier scan finished, computes the cycle of the next timed launch, and pulses `start` into that cycle. It then requires the next completion exactly one interval after the previous one, and the following completion one more interval later, which shows that one scan ran and the timer restarted once. A related case places `start` in the middle of a running scan and judges it by the same completion spacing.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOAD  = 2'd1,
        S_GAP   = 2'd2,
        S_SHIFT = 2'd3
    } scan_st_e;
endpackage

// File: rtl/scan_interval_timer.sv
module scan_interval_timer #(
    parameter int INTERVAL = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] TICK_AT = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == TICK_AT);

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (!tick)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int TOT = 16,
    parameter int DIV = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig,
    input  logic           miso,
    output logic           launch,
    output logic           load_n,
    output logic           sclk,
    output logic [TOT-1:0] word,
    output logic           fin
);
    localparam int HALF = DIV / 2;
    localparam int HW   = $clog2(DIV);
    localparam int BW   = $clog2(TOT);
    localparam logic [HW-1:0] LD_END   = HW'(DIV - 1);
    localparam logic [HW-1:0] HALF_END = HW'(HALF - 1);
    localparam logic [BW-1:0] BIT_END  = BW'(TOT - 1);

    typedef struct packed {
        scan_st_e       st;
        logic [HW-1:0]  hc;
        logic [BW-1:0]  bc;
        logic           sclk;
        logic           load_n;
        logic [TOT-1:0] sh;
        logic           fin;
    } seq_t;

    seq_t d, q;

    assign launch = (q.st == S_IDLE) && trig;
    assign load_n = q.load_n;
    assign sclk   = q.sclk;
    assign word   = q.sh;
    assign fin    = q.fin;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (trig) begin
                    d.st     = S_LOAD;
                    d.load_n = 1'b0;
                    d.hc     = '0;
                end
            end
            S_LOAD: begin
                if (q.hc == LD_END) begin
                    d.st     = S_GAP;
                    d.load_n = 1'b1;
                    d.hc     = '0;
                end else begin
                    d.hc = q.hc + HW'(1);
                end
            end
            S_GAP: begin
                if (q.hc == HALF_END) begin
                    d.st   = S_SHIFT;
                    d.sclk = 1'b1;
                    d.sh   = {q.sh[TOT-2:0], miso};
                    d.hc   = '0;
                    d.bc   = '0;
                end else begin
                    d.hc = q.hc + HW'(1);
                end
            end
            S_SHIFT: begin
                if (q.hc != HALF_END) begin
                    d.hc = q.hc + HW'(1);
                end else begin
                    d.hc = '0;
                    if (q.sclk) begin
                        d.sclk = 1'b0;
                        if (q.bc == BIT_END) begin
                            d.st  = S_IDLE;
                            d.fin = 1'b1;
                        end else begin
                            d.bc = q.bc + BW'(1);
                        end
                    end else begin
                        d.sclk = 1'b1;
                        d.sh   = {q.sh[TOT-2:0], miso};
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.load_n <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/scan_byte_router.sv
module scan_byte_router #(
    parameter int N_DEV  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin,
    input  logic [N_DEV*BYTE_W-1:0] word,
    output logic [N_DEV*BYTE_W-1:0] dout,
    output logic                    done
);
    localparam int TOT = N_DEV * BYTE_W;

    typedef struct packed {
        logic [TOT-1:0] dout;
        logic           done;
    } rt_t;

    rt_t d, q;
    logic [TOT-1:0] mapped;

    for (genvar k = 0; k < N_DEV; k++) begin : g_port
        assign mapped[k*BYTE_W +: BYTE_W] = word[TOT-1-k*BYTE_W -: BYTE_W];
    end

    always_comb begin
        d.done = fin;
        d.dout = fin ? mapped : q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.dout;
    assign done = q.done;
endmodule

// File: rtl/din_chain_scanner.sv
module din_chain_scanner #(
    parameter int N_DEV    = 2,
    parameter int BYTE_W   = 8,
    parameter int DIV      = 16,
    parameter int INTERVAL = 5_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    miso,
    output logic                    load_n,
    output logic                    sclk,
    output logic                    mosi,
    output logic [N_DEV*BYTE_W-1:0] dout,
    output logic                    done
);
    localparam int TOT = N_DEV * BYTE_W;

    logic           tick, launch, fin;
    logic [TOT-1:0] word;

    scan_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .tick    (tick)
    );

    scan_sequencer #(.TOT(TOT), .DIV(DIV)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (start | tick),
        .miso   (miso),
        .launch (launch),
        .load_n (load_n),
        .sclk   (sclk),
        .word   (word),
        .fin    (fin)
    );

    scan_byte_router #(.N_DEV(N_DEV), .BYTE_W(BYTE_W)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .fin   (fin),
        .word  (word),
        .dout  (dout),
        .done  (done)
    );

    assign mosi = 1'b0;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int DIV = 16,
    parameter int TOT = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load_n,
    input logic           sclk,
    input logic           done,
    input logic [TOT-1:0] dout
);
    localparam int HALF = DIV / 2;

    logic [15:0] lo_run, hi_run, since_ld, rises;
    logic        sk_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run   <= '0;
            hi_run   <= '0;
            since_ld <= 16'hFFFF;
            rises    <= '0;
            sk_p     <= 1'b0;
        end else begin
            sk_p     <= sclk;
            lo_run   <= load_n ? 16'd0 : lo_run + 16'd1;
            hi_run   <= sclk ? hi_run + 16'd1 : 16'd0;
            since_ld <= !load_n ? 16'd0 : (since_ld == 16'hFFFF ? since_ld : since_ld + 16'd1);
            if (!load_n)
                rises <= '0;
            else if (sclk && !sk_p)
                rises <= rises + 16'd1;
        end
    end

    assert_load_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_n) |-> lo_run == 16'(DIV));

    assert_no_clock_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !sclk);

    assert_lead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> since_ld >= 16'(HALF));

    assert_high_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_run == 16'(HALF));

    assert_edge_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rises == 16'(TOT));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_dout_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> done);
endmodule

bind din_chain_scanner scan_checker #(.DIV(DIV), .TOT(N_DEV*BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .sclk   (sclk),
    .done   (done),
    .dout   (dout)
);

// File: tb/din_chain_scanner_tb.sv
module din_chain_scanner_tb;
    localparam int N_DEV    = 2;
    localparam int BYTE_W   = 8;
    localparam int DIV      = 16;
    localparam int HALF     = DIV / 2;
    localparam int INTERVAL = 2000;
    localparam int TOT      = N_DEV * BYTE_W;
    localparam int LAT      = DIV * (TOT + 1) + 1;
    localparam int NV       = 8;
    localparam logic [15:0] VEC [NV] = '{16'hA55A, 16'h0000, 16'hFFFF, 16'h0180,
                                         16'h7F01, 16'h1234, 16'hC3E7, 16'h8001};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso;
    logic load_n, sclk, mosi, done;
    logic [TOT-1:0] dout;
    logic [7:0] par0 = '0, par1 = '0, sr0 = '0, sr1 = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int t_lf = 0, t_lr = 0, t_sr = 0, t_rl = 0, nrise = 0, half_bad = 0;
    logic first = 1'b0, ld_p = 1'b1, sk_p = 1'b0;

    always #10 clk = ~clk;

    din_chain_scanner #(.N_DEV(N_DEV), .BYTE_W(BYTE_W), .DIV(DIV), .INTERVAL(INTERVAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
        .load_n(load_n), .sclk(sclk), .mosi(mosi), .dout(dout), .done(done)
    );

    // two-device chain model: device 0 drives miso, device 1 feeds device 0
    always @(posedge sclk or negedge load_n) begin
        if (!load_n) begin
            sr0 <= par0;
            sr1 <= par1;
        end else begin
            sr0 <= {sr0[6:0], sr1[7]};
            sr1 <= {sr1[6:0], 1'b0};
        end
    end
    assign miso = sr0[7];

    // timing monitor; times are the index of the edge after which a change shows
    always @(posedge clk) begin
        if (ld_p && !load_n) begin
            t_lf <= cyc; nrise <= 0; half_bad <= 0; first <= 1'b1;
        end
        if (!ld_p && load_n) t_lr <= cyc;
        if (!sk_p && sclk) begin
            nrise <= nrise + 1;
            t_rl  <= cyc;
            if (first) begin
                t_sr <= cyc; first <= 1'b0;
            end else if (cyc - t_rl != DIV) begin
                half_bad <= half_bad + 1;
            end
        end
        if (sk_p && !sclk && (cyc - t_rl != HALF)) half_bad <= half_bad + 1;
        ld_p <= load_n;
        sk_p <= sclk;
        cyc  <= cyc + 1;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_done(output int t);
        int n = 0;
        @(negedge clk);
        while (!done && n < 3 * INTERVAL) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R8 done timeout", 0, 1);
        t = cyc;
    endtask

    task automatic pulse_start(output int accept_edge);
        start = 1'b1;
        accept_edge = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_scan(input logic [15:0] v, output int t_done);
        int x;
        par0 = v[7:0];
        par1 = v[15:8];
        @(negedge clk);
        pulse_start(x);
        wait_done(t_done);
        chk(t_done - x == LAT, "R8 latency", t_done - x, LAT);
        chk(dout == v, "R5 byte order", dout, v);
        chk(t_lr - t_lf == DIV, "R2 load width", t_lr - t_lf, DIV);
        chk(t_sr - t_lr == HALF, "R3 lead gap", t_sr - t_lr, HALF);
        chk(nrise == TOT, "R4 edge count", nrise, TOT);
        chk(half_bad == 0, "R4 clock period", half_bad, 0);
        chk(mosi == 1'b0, "R6 mosi", mosi, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done width", done, 0);
        chk(dout == v, "R7 dout hold", dout, v);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        finish_up();
    end

    initial begin
        int d1, d2, d3, x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(load_n == 1'b1, "R1 load_n", load_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(dout == '0, "R1 dout", dout, 0);
        chk(mosi == 1'b0, "R6 mosi idle", mosi, 0);

        for (int i = 0; i < NV; i++) run_scan(VEC[i], d1);

        // R2: parallel inputs changed after the load are not captured
        par0 = 8'h3C; par1 = 8'hD2;
        @(negedge clk);
        pulse_start(x);
        while (!load_n || cyc < x + 1) @(negedge clk);
        par0 = 8'hFF; par1 = 8'h00;
        wait_done(d1);
        chk(dout == 16'hD23C, "R2 late input change", dout, 16'hD23C);

        // R11: start lands in the cycle of the timer expiry
        par0 = 8'h5A; par1 = 8'h96;
        while (cyc < d1 - LAT + INTERVAL - 1) @(negedge clk);
        pulse_start(x);
        wait_done(d2);
        chk(d2 == d1 + INTERVAL, "R11 coincident launch", d2 - d1, INTERVAL);
        chk(dout == 16'h965A, "R11 data", dout, 16'h965A);
        wait_done(d3);
        chk(d3 == d2 + INTERVAL, "R11 single restart", d3 - d2, INTERVAL);
        wait_done(d1);
        chk(d1 == d3 + INTERVAL, "R9 timed period", d1 - d3, INTERVAL);

        // R10: start during a scan is ignored
        @(negedge clk);
        pulse_start(x);
        repeat (40) @(negedge clk);
        pulse_start(d3);
        wait_done(d1);
        chk(d1 - x == LAT, "R10 busy start latency", d1 - x, LAT);
        wait_done(d2);
        chk(d2 - d1 == INTERVAL, "R10 no extra scan", d2 - d1, INTERVAL);
        chk(dout == 16'h965A, "R9 timed scan data", dout, 16'h965A);

        finish_up();
    end
endmodule